// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the control-register bookkeeping that a small 32-bit RISC core needs when it leaves normal flow. The events are power-on reset, manual reset, general fault, address-translation miss, trap instruction and external interrupt. It holds the architectural status and control state, and every event is taken in one clock edge: the program counter, the status word, the shadow copies and the cause registers. It also holds a sixteen-entry general register file whose lower eight entries exist twice. The active copy is exchanged with the alternate copy whenever the bank-select bit of the status word changes.

Decode, the ALU, the translation unit and interrupt-priority arbitration are outside the block. They present already-encoded requests with codes. The core uses a few plain operations: step the PC, mark a branch delay slot, write the status word or vector base, and write or read a general register. The block reports the redirected PC with a one-cycle pulse. It raises a sticky halt flag when a fault arrives with no vector base set up, and it reports the low-power state that a sleep request has entered.

Status word fields: privilege MD = bit 30, bank select RB = bit 29, event block BL = bit 28, interrupt mask = bits 7:4.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After `rst` (synchronous, active high): PC = 0xA0000000, NPC = 0xA0000002, VBR = 0, SR = 0x700000F0, FPSCR = 0x00040001, EXPEVT = 0x000, halt = 0, power state = 0 (run), and all general registers read 0.
- R2: A manual reset request loads EXPEVT with its code, PC with 0xA0000000 and NPC with PC+2. It ORs bits 30, 29, 28 and 7:4 into SR, clears halt and returns the power state to run. It is honoured even while halted or asleep.
- R3: A general fault with VBR ≠ 0 copies PC to SPC, SR to SSR and R15 to SGR. It loads EXPEVT with the fault code, PC with VBR+0x100 and NPC with PC+2, and ORs bits 30, 29 and 28 into SR.
- R4: A fault flagged as a translation miss does the same as R3 but sets PC to VBR+0x400.
- R5: An interrupt request saves SPC, SSR and SGR as in R3. It writes its code to INTEVT and leaves EXPEVT unchanged, sets PC to VBR+0x600, and ORs bits 30, 29 and 28 into SR. It is ignored while SR bit 28 is 1.
- R6: A trap request loads TRA with its 8-bit immediate times four and then enters as in R3 with code 0x160.
- R7: `slot_enter` sets the in-slot flag and a PC step without `slot_enter` clears it. A fault taken while the flag is set uses the slot code instead of the normal code. Any event entry clears the flag.
- R8: Every SR update that changes bit 29 exchanges the eight active R0–R7 with the alternate eight. A register write in the same cycle lands in the copy that was active before the exchange. R8–R15 are never exchanged.
- R9: A fault or trap while VBR = 0 sets halt and leaves PC, NPC, SR, SPC, SSR, SGR and EXPEVT unchanged; a trap still writes TRA. While halted, only reset and manual reset have any effect.
- R10: A sleep request sets the power state to 2 when bit 7 of `stby_ctl` is 1 and to 1 otherwise. While the power state is nonzero, faults, traps, sleep and the plain operations are ignored. An accepted interrupt or a manual reset returns the state to 0.
- R11: Priority is manual reset, then fault, then trap, then interrupt, then sleep. All plain operations are dropped in a cycle that takes any of these.
- R12: `redirect` is 1 for exactly the cycle after a manual reset, fault, miss, trap or interrupt entry, and 0 otherwise.
- R13: A PC step in an event-free running cycle sets PC to the old NPC and NPC to the old NPC+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mrst_req | input | 1 | Manual reset request |
| mrst_code | input | 12 | Cause code for manual reset |
| exc_req | input | 1 | Fault request |
| exc_tlb | input | 1 | Fault is a translation miss |
| exc_code | input | 12 | Fault code outside a delay slot |
| exc_slot_code | input | 12 | Fault code inside a delay slot |
| trap_req | input | 1 | Trap instruction request |
| trap_imm | input | 8 | Trap immediate |
| irq_req | input | 1 | Interrupt request |
| irq_code | input | 12 | Interrupt cause code |
| sleep_req | input | 1 | Sleep instruction request |
| stby_ctl | input | 8 | Power control byte; bit 7 selects standby |
| sr_we | input | 1 | Status word write |
| sr_wdata | input | 32 | Status word write data |
| vbr_we | input | 1 | Vector base write |
| vbr_wdata | input | 32 | Vector base write data |
| pc_step | input | 1 | Advance PC |
| slot_enter | input | 1 | Next instruction is a delay slot |
| gpr_we | input | 1 | General register write |
| gpr_waddr | input | 4 | Write index |
| gpr_wdata | input | 32 | Write data |
| gpr_raddr | input | 4 | Read index |
| gpr_rdata | output | 32 | Read data (combinational) |
| pc | output | 32 | Program counter |
| npc | output | 32 | Next program counter |
| sr | output | 32 | Status word |
| spc | output | 32 | Saved PC |
| ssr | output | 32 | Saved status word |
| sgr | output | 32 | Saved R15 |
| vbr | output | 32 | Vector base |
| expevt | output | 12 | Fault/reset cause |
| intevt | output | 12 | Interrupt cause |
| tra | output | 32 | Trap immediate times four |
| fpscr | output | 32 | Floating-point status reset value |
| in_slot | output | 1 | Delay-slot flag |
| halt | output | 1 | Sticky halt on missing vector base |
| pwr_state | output | 2 | 0 run, 1 sleep, 2 standby |
| redirect | output | 1 | PC redirected in previous cycle |

## Verification
A wrong bank exchange stays hidden until the next read of R0–R7, which can be many cycles later. The bench therefore reads a random register every cycle and compares it with a reference that tracks both copies. Wrong shadow or cause values appear on the outputs one edge after the entry. A wrongly sticky or missed halt or sleep state shows up as frozen PC or ignored requests from then on. The reference compares every output after every edge under mixed random requests, so any divergence is caught in the cycle it first becomes visible.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN   = 32;
    localparam int CODE_W = 12;

    localparam int SR_MD = 30;
    localparam int SR_RB = 29;
    localparam int SR_BL = 28;
    localparam logic [XLEN-1:0] SR_IMASK = 32'h0000_00F0;

    localparam logic [XLEN-1:0] RST_PC    = 32'hA000_0000;
    localparam logic [XLEN-1:0] RST_SR    = 32'h7000_00F0;
    localparam logic [XLEN-1:0] RST_FPSCR = 32'h0004_0001;

    localparam logic [XLEN-1:0] OFS_GEN = 32'h0000_0100;
    localparam logic [XLEN-1:0] OFS_TLB = 32'h0000_0400;
    localparam logic [XLEN-1:0] OFS_IRQ = 32'h0000_0600;

    localparam logic [CODE_W-1:0] CODE_POR  = 12'h000;
    localparam logic [CODE_W-1:0] CODE_TRAP = 12'h160;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_MRST  = 3'd1,
        EV_EXC   = 3'd2,
        EV_TLB   = 3'd3,
        EV_TRAP  = 3'd4,
        EV_IRQ   = 3'd5,
        EV_HALT  = 3'd6,
        EV_SLEEP = 3'd7
    } ev_kind_e;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_SLEEP = 2'd1,
        PWR_STBY  = 2'd2
    } pwr_e;

    typedef struct packed {
        ev_kind_e          kind;
        logic [CODE_W-1:0] code;
    } ev_sel_t;

    function automatic logic [XLEN-1:0] sr_on_entry(input logic [XLEN-1:0] s);
        return s | (32'h1 << SR_MD) | (32'h1 << SR_RB) | (32'h1 << SR_BL);
    endfunction

    function automatic logic [XLEN-1:0] sr_on_mreset(input logic [XLEN-1:0] s);
        return sr_on_entry(s) | SR_IMASK;
    endfunction

    function automatic logic is_entry(input ev_kind_e k);
        return (k == EV_EXC) || (k == EV_TLB) || (k == EV_TRAP) || (k == EV_IRQ);
    endfunction

    function automatic logic [XLEN-1:0] ev_vector(input logic [XLEN-1:0] base,
                                                  input ev_kind_e k);
        case (k)
            EV_TLB:  return base + OFS_TLB;
            EV_IRQ:  return base + OFS_IRQ;
            default: return base + OFS_GEN;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mrst_req,
    input  logic [CODE_W-1:0] mrst_code,
    input  logic              exc_req,
    input  logic              exc_tlb,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] exc_slot_code,
    input  logic              trap_req,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              sleep_req,
    input  logic              in_slot,
    input  logic              sr_bl,
    input  logic              vbr_zero,
    input  logic              halted,
    input  logic              asleep,
    output ev_sel_t           sel,
    output logic              trap_fire,
    output logic              cpu_op
);

    logic run;

    always_comb begin
        run       = !halted && !asleep;
        sel.kind  = EV_NONE;
        sel.code  = '0;
        trap_fire = 1'b0;
        if (mrst_req) begin
            sel.kind = EV_MRST;
            sel.code = mrst_code;
        end else if (run && exc_req) begin
            sel.kind = vbr_zero ? EV_HALT : (exc_tlb ? EV_TLB : EV_EXC);
            sel.code = in_slot ? exc_slot_code : exc_code;
        end else if (run && trap_req) begin
            trap_fire = 1'b1;
            sel.kind  = vbr_zero ? EV_HALT : EV_TRAP;
            sel.code  = CODE_TRAP;
        end else if (!halted && irq_req && !sr_bl) begin
            sel.kind = EV_IRQ;
            sel.code = irq_code;
        end else if (run && sleep_req) begin
            sel.kind = EV_SLEEP;
        end
        cpu_op = run && (sel.kind == EV_NONE);
    end

    p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
        sr_bl |-> sel.kind != EV_IRQ);

    p_mrst_first_r11: assert property (@(posedge clk) disable iff (rst)
        mrst_req |-> sel.kind == EV_MRST);

    p_sleep_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        (asleep && !mrst_req) |-> (sel.kind == EV_NONE || sel.kind == EV_IRQ) && !cpu_op);

endmodule

// File: rtl/exc_gpr_bank.sv
module exc_gpr_bank #(
    parameter  int NREG  = 16,
    parameter  int NBANK = 8,
    parameter  int W     = 32,
    localparam int RA_W  = $clog2(NREG),
    localparam int NHI   = NREG - NBANK
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            swap,
    input  logic            we,
    input  logic [RA_W-1:0] waddr,
    input  logic [W-1:0]    wdata,
    input  logic [RA_W-1:0] raddr,
    output logic [W-1:0]    rdata,
    output logic [W-1:0]    r_top
);

    logic [W-1:0] act [NBANK];
    logic [W-1:0] alt [NBANK];
    logic [W-1:0] hi  [NHI];

    for (genvar i = 0; i < NBANK; i++) begin : g_banked
        logic [W-1:0] merged;
        assign merged = (we && waddr == RA_W'(i)) ? wdata : act[i];
        always_ff @(posedge clk) begin
            if (rst) begin
                act[i] <= '0;
                alt[i] <= '0;
            end else if (swap) begin
                act[i] <= alt[i];
                alt[i] <= merged;
            end else begin
                act[i] <= merged;
            end
        end
    end

    for (genvar j = 0; j < NHI; j++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst) begin
                hi[j] <= '0;
            end else if (we && waddr == RA_W'(j + NBANK)) begin
                hi[j] <= wdata;
            end
        end
    end

    always_comb begin
        if (raddr < RA_W'(NBANK)) begin
            rdata = act[raddr[$clog2(NBANK)-1:0]];
        end else begin
            rdata = hi[raddr - RA_W'(NBANK)];
        end
    end

    assign r_top = hi[NHI-1];

    p_swap_r8: assert property (@(posedge clk) disable iff (rst)
        swap |=> act[0] == $past(alt[0]));

    p_top_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!we || waddr != RA_W'(NREG-1)) |=> $stable(hi[NHI-1]));

endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ev_sel_t           sel,
    input  logic              trap_fire,
    input  logic [7:0]        trap_imm,
    input  logic              stby_bit,
    input  logic              cpu_op,
    input  logic              sr_we,
    input  logic [XLEN-1:0]   sr_wdata,
    input  logic              vbr_we,
    input  logic [XLEN-1:0]   vbr_wdata,
    input  logic              pc_step,
    input  logic              slot_enter,
    input  logic [XLEN-1:0]   r_top,
    output logic              swap,
    output logic [XLEN-1:0]   pc_q,
    output logic [XLEN-1:0]   npc_q,
    output logic [XLEN-1:0]   sr_q,
    output logic [XLEN-1:0]   spc_q,
    output logic [XLEN-1:0]   ssr_q,
    output logic [XLEN-1:0]   sgr_q,
    output logic [XLEN-1:0]   vbr_q,
    output logic [CODE_W-1:0] expevt_q,
    output logic [CODE_W-1:0] intevt_q,
    output logic [XLEN-1:0]   tra_q,
    output logic [XLEN-1:0]   fpscr_q,
    output logic              slot_q,
    output logic              halt_q,
    output pwr_e              pwr_q,
    output logic              redirect_q
);

    logic [XLEN-1:0] sr_nxt;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] tra_val;

    always_comb begin
        case (sel.kind)
            EV_MRST:                         sr_nxt = sr_on_mreset(sr_q);
            EV_EXC, EV_TLB, EV_TRAP, EV_IRQ: sr_nxt = sr_on_entry(sr_q);
            EV_NONE:                         sr_nxt = (cpu_op && sr_we) ? sr_wdata : sr_q;
            default:                         sr_nxt = sr_q;
        endcase
    end

    assign swap    = !rst && (sr_nxt[SR_RB] != sr_q[SR_RB]);
    assign target  = ev_vector(vbr_q, sel.kind);
    assign tra_val = {{(XLEN-10){1'b0}}, trap_imm, 2'b00};

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= RST_PC;
            npc_q      <= RST_PC + 32'd2;
            sr_q       <= RST_SR;
            spc_q      <= '0;
            ssr_q      <= '0;
            sgr_q      <= '0;
            vbr_q      <= '0;
            expevt_q   <= CODE_POR;
            intevt_q   <= '0;
            tra_q      <= '0;
            fpscr_q    <= RST_FPSCR;
            slot_q     <= 1'b0;
            halt_q     <= 1'b0;
            pwr_q      <= PWR_RUN;
            redirect_q <= 1'b0;
        end else begin
            sr_q       <= sr_nxt;
            redirect_q <= 1'b0;
            case (sel.kind)
                EV_MRST: begin
                    expevt_q   <= sel.code;
                    pc_q       <= RST_PC;
                    npc_q      <= RST_PC + 32'd2;
                    halt_q     <= 1'b0;
                    pwr_q      <= PWR_RUN;
                    slot_q     <= 1'b0;
                    redirect_q <= 1'b1;
                end
                EV_EXC, EV_TLB, EV_TRAP, EV_IRQ: begin
                    spc_q      <= pc_q;
                    ssr_q      <= sr_q;
                    sgr_q      <= r_top;
                    pc_q       <= target;
                    npc_q      <= target + 32'd2;
                    slot_q     <= 1'b0;
                    redirect_q <= 1'b1;
                    if (sel.kind == EV_IRQ) begin
                        intevt_q <= sel.code;
                        pwr_q    <= PWR_RUN;
                    end else begin
                        expevt_q <= sel.code;
                    end
                    if (sel.kind == EV_TRAP) begin
                        tra_q <= tra_val;
                    end
                end
                EV_HALT: begin
                    halt_q <= 1'b1;
                    if (trap_fire) begin
                        tra_q <= tra_val;
                    end
                end
                EV_SLEEP: begin
                    pwr_q <= stby_bit ? PWR_STBY : PWR_SLEEP;
                end
                default: begin
                    if (cpu_op) begin
                        if (vbr_we) begin
                            vbr_q <= vbr_wdata;
                        end
                        if (pc_step) begin
                            pc_q  <= npc_q;
                            npc_q <= npc_q + 32'd2;
                        end
                        if (slot_enter) begin
                            slot_q <= 1'b1;
                        end else if (pc_step) begin
                            slot_q <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    p_entry_saves_r3: assert property (@(posedge clk) disable iff (rst)
        is_entry(sel.kind) |=> spc_q == $past(pc_q) && ssr_q == $past(sr_q));

    p_entry_sr_r3: assert property (@(posedge clk) disable iff (rst)
        is_entry(sel.kind) |=> sr_q[SR_MD] && sr_q[SR_RB] && sr_q[SR_BL] && !slot_q);

    p_mrst_pc_r2: assert property (@(posedge clk) disable iff (rst)
        sel.kind == EV_MRST |=> pc_q == RST_PC && sr_q[7:4] == 4'hF && !halt_q);

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (halt_q && sel.kind != EV_MRST) |=> halt_q && $stable(pc_q) && $stable(sr_q));

    p_redirect_r12: assert property (@(posedge clk) disable iff (rst)
        redirect_q |-> $past(sel.kind) != EV_NONE);

    p_step_r13: assert property (@(posedge clk) disable iff (rst)
        (cpu_op && pc_step) |=> pc_q == $past(npc_q));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter  int NREG  = 16,
    parameter  int NBANK = 8,
    localparam int RA_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrst_req,
    input  logic [CODE_W-1:0] mrst_code,
    input  logic              exc_req,
    input  logic              exc_tlb,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] exc_slot_code,
    input  logic              trap_req,
    input  logic [7:0]        trap_imm,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              sleep_req,
    input  logic [7:0]        stby_ctl,
    input  logic              sr_we,
    input  logic [XLEN-1:0]   sr_wdata,
    input  logic              vbr_we,
    input  logic [XLEN-1:0]   vbr_wdata,
    input  logic              pc_step,
    input  logic              slot_enter,
    input  logic              gpr_we,
    input  logic [RA_W-1:0]   gpr_waddr,
    input  logic [XLEN-1:0]   gpr_wdata,
    input  logic [RA_W-1:0]   gpr_raddr,
    output logic [XLEN-1:0]   gpr_rdata,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   npc,
    output logic [XLEN-1:0]   sr,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   sgr,
    output logic [XLEN-1:0]   vbr,
    output logic [CODE_W-1:0] expevt,
    output logic [CODE_W-1:0] intevt,
    output logic [XLEN-1:0]   tra,
    output logic [XLEN-1:0]   fpscr,
    output logic              in_slot,
    output logic              halt,
    output logic [1:0]        pwr_state,
    output logic              redirect
);

    ev_sel_t         sel;
    logic            trap_fire;
    logic            cpu_op;
    logic            swap;
    logic [XLEN-1:0] r_top;
    pwr_e            pwr_q;

    exc_arbiter u_arb (
        .clk           (clk),
        .rst           (rst),
        .mrst_req      (mrst_req),
        .mrst_code     (mrst_code),
        .exc_req       (exc_req),
        .exc_tlb       (exc_tlb),
        .exc_code      (exc_code),
        .exc_slot_code (exc_slot_code),
        .trap_req      (trap_req),
        .irq_req       (irq_req),
        .irq_code      (irq_code),
        .sleep_req     (sleep_req),
        .in_slot       (in_slot),
        .sr_bl         (sr[SR_BL]),
        .vbr_zero      (vbr == '0),
        .halted        (halt),
        .asleep        (pwr_q != PWR_RUN),
        .sel           (sel),
        .trap_fire     (trap_fire),
        .cpu_op        (cpu_op)
    );

    exc_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .trap_fire  (trap_fire),
        .trap_imm   (trap_imm),
        .stby_bit   (stby_ctl[7]),
        .cpu_op     (cpu_op),
        .sr_we      (sr_we),
        .sr_wdata   (sr_wdata),
        .vbr_we     (vbr_we),
        .vbr_wdata  (vbr_wdata),
        .pc_step    (pc_step),
        .slot_enter (slot_enter),
        .r_top      (r_top),
        .swap       (swap),
        .pc_q       (pc),
        .npc_q      (npc),
        .sr_q       (sr),
        .spc_q      (spc),
        .ssr_q      (ssr),
        .sgr_q      (sgr),
        .vbr_q      (vbr),
        .expevt_q   (expevt),
        .intevt_q   (intevt),
        .tra_q      (tra),
        .fpscr_q    (fpscr),
        .slot_q     (in_slot),
        .halt_q     (halt),
        .pwr_q      (pwr_q),
        .redirect_q (redirect)
    );

    exc_gpr_bank #(
        .NREG  (NREG),
        .NBANK (NBANK),
        .W     (XLEN)
    ) u_gpr (
        .clk   (clk),
        .rst   (rst),
        .swap  (swap),
        .we    (gpr_we && cpu_op),
        .waddr (gpr_waddr),
        .wdata (gpr_wdata),
        .raddr (gpr_raddr),
        .rdata (gpr_rdata),
        .r_top (r_top)
    );

    assign pwr_state = pwr_q;

endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int K_NONE = 0, K_MRST = 1, K_EXC = 2, K_TLB = 3,
                   K_TRAP = 4, K_IRQ = 5, K_HALT = 6, K_SLEEP = 7;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst, mrst_req, exc_req, exc_tlb, trap_req, irq_req, sleep_req;
    logic [11:0] mrst_code, exc_code, exc_slot_code, irq_code, expevt, intevt;
    logic [7:0]  trap_imm, stby_ctl;
    logic        sr_we, vbr_we, pc_step, slot_enter, gpr_we;
    logic [31:0] sr_wdata, vbr_wdata, gpr_wdata, gpr_rdata;
    logic [3:0]  gpr_waddr, gpr_raddr;
    logic [31:0] pc, npc, sr, spc, ssr, sgr, vbr, tra, fpscr;
    logic        in_slot, halt, redirect;
    logic [1:0]  pwr_state;

    exc_entry_ctrl u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] m_pc, m_npc, m_sr, m_spc, m_ssr, m_sgr, m_vbr, m_tra;
    logic [11:0] m_expevt, m_intevt;
    logic        m_slot, m_halt, m_redir;
    logic [1:0]  m_pwr;
    logic [31:0] m_act [8];
    logic [31:0] m_alt [8];
    logic [31:0] m_hi  [8];
    string       cur_tag;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic clr_in();
        rst = 0; mrst_req = 0; exc_req = 0; exc_tlb = 0; trap_req = 0;
        irq_req = 0; sleep_req = 0; sr_we = 0; vbr_we = 0; pc_step = 0;
        slot_enter = 0; gpr_we = 0;
        mrst_code = 0; exc_code = 0; exc_slot_code = 0; irq_code = 0;
        trap_imm = 0; stby_ctl = 0; sr_wdata = 0; vbr_wdata = 0;
        gpr_waddr = 0; gpr_wdata = 0; gpr_raddr = 0;
    endtask

    function automatic logic [31:0] f_entry_sr(logic [31:0] s);
        return s | 32'h7000_0000;
    endfunction

    task automatic model_reset();
        m_pc = 32'hA000_0000; m_npc = 32'hA000_0002; m_sr = 32'h7000_00F0;
        m_spc = 0; m_ssr = 0; m_sgr = 0; m_vbr = 0; m_tra = 0;
        m_expevt = 0; m_intevt = 0; m_slot = 0; m_halt = 0; m_redir = 0; m_pwr = 0;
        for (int i = 0; i < 8; i++) begin
            m_act[i] = 0; m_alt[i] = 0; m_hi[i] = 0;
        end
    endtask

    task automatic model_step();
        bit          run;
        int          k;
        logic [11:0] code;
        logic [31:0] nsr, tgt, tmp;
        if (rst) begin
            model_reset();
            cur_tag = "R1";
            return;
        end
        run  = !m_halt && (m_pwr == 2'd0);
        k    = K_NONE;
        code = 0;
        if (mrst_req) begin
            k = K_MRST; code = mrst_code;
        end else if (run && exc_req) begin
            k = (m_vbr == 0) ? K_HALT : (exc_tlb ? K_TLB : K_EXC);
            code = m_slot ? exc_slot_code : exc_code;
        end else if (run && trap_req) begin
            k = (m_vbr == 0) ? K_HALT : K_TRAP; code = 12'h160;
            m_tra = {22'b0, trap_imm, 2'b00};
        end else if (!m_halt && irq_req && !m_sr[28]) begin
            k = K_IRQ; code = irq_code;
        end else if (run && sleep_req) begin
            k = K_SLEEP;
        end
        case (k)
            K_MRST:  cur_tag = "R2";
            K_EXC:   cur_tag = m_slot ? "R7" : "R3";
            K_TLB:   cur_tag = "R4";
            K_TRAP:  cur_tag = "R6";
            K_IRQ:   cur_tag = "R5";
            K_HALT:  cur_tag = "R9";
            K_SLEEP: cur_tag = "R10";
            default: cur_tag = "R13";
        endcase
        if (mrst_req && (exc_req || trap_req || irq_req || sleep_req)) cur_tag = "R11";
        nsr     = m_sr;
        m_redir = 0;
        tgt     = m_vbr + ((k == K_TLB) ? 32'h400 : (k == K_IRQ) ? 32'h600 : 32'h100);
        case (k)
            K_MRST: begin
                nsr = f_entry_sr(m_sr) | 32'hF0; m_expevt = code;
                m_pc = 32'hA000_0000; m_npc = 32'hA000_0002;
                m_halt = 0; m_pwr = 0; m_slot = 0; m_redir = 1;
            end
            K_EXC, K_TLB, K_TRAP, K_IRQ: begin
                m_spc = m_pc; m_ssr = m_sr; m_sgr = m_hi[7];
                nsr = f_entry_sr(m_sr); m_pc = tgt; m_npc = tgt + 2;
                m_slot = 0; m_redir = 1;
                if (k == K_IRQ) begin
                    m_intevt = code; m_pwr = 0;
                end else begin
                    m_expevt = code;
                end
            end
            K_HALT:  m_halt = 1;
            K_SLEEP: m_pwr = stby_ctl[7] ? 2'd2 : 2'd1;
            default: begin
                if (run) begin
                    if (sr_we)  nsr   = sr_wdata;
                    if (vbr_we) m_vbr = vbr_wdata;
                    if (pc_step) begin
                        m_pc = m_npc; m_npc = m_npc + 2;
                    end
                    if (slot_enter)   m_slot = 1;
                    else if (pc_step) m_slot = 0;
                    if (gpr_we) begin
                        if (gpr_waddr < 8) m_act[gpr_waddr[2:0]] = gpr_wdata;
                        else               m_hi[gpr_waddr[2:0]]  = gpr_wdata;
                    end
                end
            end
        endcase
        if (nsr[29] != m_sr[29]) begin
            for (int i = 0; i < 8; i++) begin
                tmp = m_act[i]; m_act[i] = m_alt[i]; m_alt[i] = tmp;
            end
        end
        m_sr = nsr;
    endtask

    task automatic compare_all();
        logic [31:0] rd;
        rd = (gpr_raddr < 8) ? m_act[gpr_raddr[2:0]] : m_hi[gpr_raddr[2:0]];
        chk({cur_tag, " pc"},     pc, m_pc);
        chk({cur_tag, " npc"},    npc, m_npc);
        chk({cur_tag, " sr"},     sr, m_sr);
        chk({cur_tag, " spc"},    spc, m_spc);
        chk({cur_tag, " ssr"},    ssr, m_ssr);
        chk({cur_tag, " sgr"},    sgr, m_sgr);
        chk({cur_tag, " vbr"},    vbr, m_vbr);
        chk({cur_tag, " expevt"}, {20'b0, expevt}, {20'b0, m_expevt});
        chk({cur_tag, " intevt"}, {20'b0, intevt}, {20'b0, m_intevt});
        chk("R6 tra",             tra, m_tra);
        chk("R1 fpscr",           fpscr, 32'h0004_0001);
        chk("R7 in_slot",         {31'b0, in_slot}, {31'b0, m_slot});
        chk("R9 halt",            {31'b0, halt}, {31'b0, m_halt});
        chk("R10 pwr_state",      {30'b0, pwr_state}, {30'b0, m_pwr});
        chk("R12 redirect",       {31'b0, redirect}, {31'b0, m_redir});
        chk("R8 gpr_rdata",       gpr_rdata, rd);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        compare_all();
        @(negedge clk);
        clr_in();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        clr_in();
        @(negedge clk);
        rst = 1; tick();
        // R1 reset values
        chk("R1 pc", pc, 32'hA000_0000);
        chk("R1 sr", sr, 32'h7000_00F0);
        chk("R1 vbr", vbr, 32'h0);

        vbr_we = 1; vbr_wdata = 32'h8C00_0000; tick();
        gpr_we = 1; gpr_waddr = 4'd15; gpr_wdata = 32'h1234; tick();
        gpr_we = 1; gpr_waddr = 4'd0; gpr_wdata = 32'hAAAA; tick();
        sr_we = 1; sr_wdata = 32'h4000_00F0; gpr_raddr = 4'd0; tick();
        chk("R8 swapped bank reads alternate", gpr_rdata, 32'h0);
        gpr_we = 1; gpr_waddr = 4'd0; gpr_wdata = 32'h5555; tick();
        exc_req = 1; exc_code = 12'h0E0; exc_slot_code = 12'h1A0; gpr_raddr = 4'd0; tick();
        chk("R3 pc", pc, 32'h8C00_0100);
        chk("R3 spc", spc, 32'hA000_0000);
        chk("R3 sgr", sgr, 32'h1234);
        chk("R3 ssr", ssr, 32'h4000_00F0);
        chk("R8 entry swaps back", gpr_rdata, 32'hAAAA);

        trap_req = 1; trap_imm = 8'h3C; tick();
        chk("R6 tra", tra, 32'hF0);
        chk("R6 expevt", {20'b0, expevt}, 32'h160);
        irq_req = 1; irq_code = 12'h320; tick();
        chk("R5 masked irq leaves pc", pc, 32'h8C00_0100);
        sr_we = 1; sr_wdata = 32'h4000_00F0; tick();
        irq_req = 1; irq_code = 12'h320; exc_tlb = 1; tick();
        chk("R5 pc", pc, 32'h8C00_0600);
        chk("R5 intevt", {20'b0, intevt}, 32'h320);

        exc_req = 1; exc_tlb = 1; exc_code = 12'h040; tick();
        chk("R4 pc", pc, 32'h8C00_0400);
        sr_we = 1; sr_wdata = 32'h4000_0000; tick();
        sleep_req = 1; stby_ctl = 8'h80; tick();
        chk("R10 standby", {30'b0, pwr_state}, 32'd2);
        exc_req = 1; exc_code = 12'h0E0; pc_step = 1; tick();
        chk("R10 asleep ignores fault", pc, 32'h8C00_0400);
        irq_req = 1; irq_code = 12'h340; tick();
        chk("R10 irq wakes", {30'b0, pwr_state}, 32'd0);
        sr_we = 1; sr_wdata = 32'h4000_0000; tick();
        sleep_req = 1; stby_ctl = 8'h00; tick();
        chk("R10 plain sleep", {30'b0, pwr_state}, 32'd1);
        mrst_req = 1; mrst_code = 12'h020; tick();

        vbr_we = 1; vbr_wdata = 32'h8C00_0000; tick();
        slot_enter = 1; pc_step = 1; tick();
        chk("R7 slot set", {31'b0, in_slot}, 32'd1);
        exc_req = 1; exc_code = 12'h180; exc_slot_code = 12'h1A0; tick();
        chk("R7 slot code", {20'b0, expevt}, 32'h1A0);
        chk("R7 slot cleared", {31'b0, in_slot}, 32'd0);

        vbr_we = 1; vbr_wdata = 32'h0; tick();
        exc_req = 1; exc_code = 12'h0E0; tick();
        chk("R9 halt", {31'b0, halt}, 32'd1);
        chk("R9 pc frozen", pc, 32'h8C00_0100);
        mrst_req = 1; mrst_code = 12'h020; exc_req = 1; irq_req = 1; tick();
        chk("R11 manual reset wins", pc, 32'hA000_0000);
        chk("R2 mask bits", {28'b0, sr[7:4]}, 32'hF);
        chk("R12 redirect", {31'b0, redirect}, 32'd1);
        tick();
        chk("R12 redirect drops", {31'b0, redirect}, 32'd0);

        for (int n = 0; n < 4000; n++) begin
            rst           = ($urandom % 500) == 0;
            mrst_req      = ($urandom % 60) == 0;
            mrst_code     = 12'($urandom);
            exc_req       = ($urandom % 20) == 0;
            exc_tlb       = 1'($urandom);
            exc_code      = 12'($urandom);
            exc_slot_code = 12'($urandom);
            trap_req      = ($urandom % 25) == 0;
            trap_imm      = 8'($urandom);
            irq_req       = ($urandom % 8) == 0;
            irq_code      = 12'($urandom);
            sleep_req     = ($urandom % 40) == 0;
            stby_ctl      = 8'($urandom);
            sr_we         = ($urandom % 8) == 0;
            sr_wdata      = $urandom;
            vbr_we        = ($urandom % 15) == 0;
            vbr_wdata     = (($urandom % 4) == 0) ? 32'h0 : ($urandom & 32'hFFFF_FFFC);
            pc_step       = 1'($urandom);
            slot_enter    = ($urandom % 10) == 0;
            gpr_we        = ($urandom % 3) == 0;
            gpr_waddr     = 4'($urandom);
            gpr_wdata     = $urandom;
            gpr_raddr     = 4'($urandom);
            tick();
        end
        finish_run();
    end

endmodule